// File: doc/BRIEF.md
# Cycle-Qualified I/O Port Decoder

This block sits on the I/O side of a small processor bus. Address and data share one bus. An address strobe marks the address phase, and the block keeps the low bits of the bus in a register while the strobe is high. The register holds that value after the strobe falls, until the next address phase. A one-of-N decoder turns the held address into a port select. The select is then combined with the cycle type to give separate input and output enables for every port.

A cycle counts as an I/O cycle only when the memory/IO line is low and exactly one of the read and write strobes is high. In a write cycle, the selected output port's register takes the bus data on the clock edge. In a read cycle, the block drives the selected input port's data onto the bus and raises its drive enable. An input port and an output port may share a port number, because the strobe keeps them apart. A memory cycle, or a cycle with both strobes high, enables nothing.

Top module: `io_pd_top`

## Requirements
- R1: While `ale` is high, the port address register takes `bus_in[ADDR_W-1:0]` on every clock edge. While `ale` is low, it holds its value.
- R2: `out_en[k]` is 1 exactly when `mem_io`=0, `wr`=1, `rd`=0 and the held address equals k.
- R3: `in_en[k]` is 1 exactly when `mem_io`=0, `rd`=1, `wr`=0 and the held address equals k.
- R4: When `mem_io`=1 (memory cycle), every enable is 0 and `bus_oe` is 0.
- R5: When `rd` and `wr` are both 1, the cycle is illegal: every enable is 0 and `bus_oe` is 0.
- R6: At most one bit of the combined `{in_en, out_en}` vector is 1 at any time.
- R7: On a clock edge where `out_en[k]` is 1, output register k (`out_regs[k*DATA_W +: DATA_W]`) loads `bus_in`. The new value is visible after that edge.
- R8: An output register whose enable is 0 keeps its value. A synchronous active-low reset clears all output registers and the held address to 0.
- R9: In a qualified read cycle, `bus_oe`=1 and `bus_out` equals input port k's data (`in_port_data[k*DATA_W +: DATA_W]`), where k is the held address. Otherwise `bus_oe`=0 and `bus_out`=0.
- R10: An input port and an output port with the same number work independently. A write to output port k leaves input port k's data path unchanged, and a read from port k leaves output register k unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ale | input | 1 | Address phase strobe, active high |
| mem_io | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| rd | input | 1 | Read strobe, active high |
| wr | input | 1 | Write strobe, active high |
| bus_in | input | DATA_W | Shared address/data bus, as seen by the block |
| in_port_data | input | NPORTS*DATA_W | Data of the input ports, port k in slice k |
| in_en | output | NPORTS | Per-port input enables |
| out_en | output | NPORTS | Per-port output enables |
| out_regs | output | NPORTS*DATA_W | Latched output-port registers, port k in slice k |
| bus_out | output | DATA_W | Data the block drives onto the bus |
| bus_oe | output | 1 | Bus drive enable |

## Verification
The assertions watch four things on every clock cycle. They check that no enable appears in a memory or illegal cycle, and that at most one enable is active. They check that an output register loads only under its enable and otherwise holds. They check that the bus is driven only in a qualified read. Only the bench's scenarios show that the enable lands on the correct port number for every address and strobe combination. The same holds for the held address surviving the data phase, read data being routed from the right port, and a shared port number keeping its input and output sides apart.

// File: rtl/io_pd_pkg.sv
// Package: shared cycle classification for the I/O port decoder.
// Assumes active-high read/write strobes and mem_io high for memory cycles.
package io_pd_pkg;

    typedef enum logic [1:0] {
        CYC_IDLE    = 2'd0,
        CYC_WRITE   = 2'd1,
        CYC_READ    = 2'd2,
        CYC_ILLEGAL = 2'd3
    } io_cyc_e;

    // Classify the current bus cycle from the control lines.
    function automatic io_cyc_e classify(input logic mem_io, input logic rd, input logic wr);
        if (mem_io)         return CYC_IDLE;
        else if (rd && wr)  return CYC_ILLEGAL;
        else if (wr)        return CYC_WRITE;
        else if (rd)        return CYC_READ;
        else                return CYC_IDLE;
    endfunction

endpackage

// File: rtl/io_pd_addr_latch.sv
// Module: io_pd_addr_latch
// Keeps the port address from the multiplexed bus while the address strobe
// is high, and holds it through the data phase until the next strobe.
// Assumes the address sits on the low ADDR_W bits of the bus.
module io_pd_addr_latch #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ale,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic [ADDR_W-1:0] addr_q
);

    // Address register: follows the bus during the strobe, holds afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n)   addr_q <= '0;
        else if (ale) addr_q <= bus_addr;
    end

    // R1: address follows the bus while the strobe is high
    a_r1_follow: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> addr_q == $past(bus_addr));

    // R1: address holds while the strobe is low
    a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ale |=> $stable(addr_q));

endmodule

// File: rtl/io_pd_decode.sv
// Module: io_pd_decode
// One-of-N decode of the held address, qualified by the cycle type,
// giving independent input and output enables for each port.
// Assumes NPORTS = 2**ADDR_W.
module io_pd_decode
    import io_pd_pkg::*;
#(
    parameter int ADDR_W = 4,
    localparam int NPORTS = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic              mem_io,
    input  logic              rd,
    input  logic              wr,
    output logic [NPORTS-1:0] in_en,
    output logic [NPORTS-1:0] out_en
);

    io_cyc_e          cyc;
    logic [NPORTS-1:0] sel;

    // Cycle type from the control lines.
    always_comb cyc = classify(mem_io, rd, wr);

    for (genvar k = 0; k < NPORTS; k++) begin : g_sel
        // Select line k: held address equals k.
        assign sel[k]    = (addr_q == ADDR_W'(k));
        // Qualified enables for port k.
        assign out_en[k] = sel[k] && (cyc == CYC_WRITE);
        assign in_en[k]  = sel[k] && (cyc == CYC_READ);
    end

    // R6: no more than one enable across both directions
    a_r6_single: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({in_en, out_en}));

    // R4: memory cycles enable no port
    a_r4_mem_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        mem_io |-> ({in_en, out_en} == '0));

    // R5: both strobes together enable no port
    a_r5_illegal: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && wr) |-> ({in_en, out_en} == '0));

endmodule

// File: rtl/io_pd_out_bank.sv
// Module: io_pd_out_bank
// Bank of output-port registers, each loading the bus under its own enable.
// Assumes enables are one-hot or zero.
module io_pd_out_bank #(
    parameter int NPORTS = 16,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NPORTS-1:0]        out_en,
    input  logic [DATA_W-1:0]        bus_in,
    output logic [NPORTS*DATA_W-1:0] out_regs
);

    for (genvar k = 0; k < NPORTS; k++) begin : g_port
        // Output register k: clear on reset, load bus data when enabled.
        always_ff @(posedge clk) begin
            if (!rst_n)        out_regs[k*DATA_W +: DATA_W] <= '0;
            else if (out_en[k]) out_regs[k*DATA_W +: DATA_W] <= bus_in;
        end

        // R7: enabled register takes the bus value
        a_r7_load: assert property (@(posedge clk) disable iff (!rst_n)
            out_en[k] |=> out_regs[k*DATA_W +: DATA_W] == $past(bus_in));

        // R8: register keeps its value when not enabled
        a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !out_en[k] |=> $stable(out_regs[k*DATA_W +: DATA_W]));
    end

endmodule

// File: rtl/io_pd_in_mux.sv
// Module: io_pd_in_mux
// Routes the enabled input port's data onto the bus and raises the drive
// enable. Assumes input enables are one-hot or zero.
module io_pd_in_mux #(
    parameter int NPORTS = 16,
    parameter int DATA_W = 8
) (
    input  logic [NPORTS-1:0]        in_en,
    input  logic [NPORTS*DATA_W-1:0] in_port_data,
    output logic [DATA_W-1:0]        bus_out,
    output logic                     bus_oe
);

    // AND-OR multiplexer: zero when no port is enabled.
    always_comb begin
        bus_out = '0;
        for (int k = 0; k < NPORTS; k++) begin
            bus_out |= in_port_data[k*DATA_W +: DATA_W] & {DATA_W{in_en[k]}};
        end
    end

    // Drive enable follows any active input enable.
    assign bus_oe = |in_en;

endmodule

// File: rtl/io_pd_top.sv
// Module: io_pd_top
// I/O port decoder for a multiplexed address/data bus: keeps the address,
// decodes it into per-port selects, qualifies them with the cycle type,
// loads output ports on writes and drives input data on reads.
// Assumes DATA_W >= ADDR_W; the bus is split into in/out/enable here.
module io_pd_top #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    localparam int NPORTS = 1 << ADDR_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ale,
    input  logic                     mem_io,
    input  logic                     rd,
    input  logic                     wr,
    input  logic [DATA_W-1:0]        bus_in,
    input  logic [NPORTS*DATA_W-1:0] in_port_data,
    output logic [NPORTS-1:0]        in_en,
    output logic [NPORTS-1:0]        out_en,
    output logic [NPORTS*DATA_W-1:0] out_regs,
    output logic [DATA_W-1:0]        bus_out,
    output logic                     bus_oe
);

    logic [ADDR_W-1:0] addr_q;

    io_pd_addr_latch #(.ADDR_W(ADDR_W)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .ale      (ale),
        .bus_addr (bus_in[ADDR_W-1:0]),
        .addr_q   (addr_q)
    );

    io_pd_decode #(.ADDR_W(ADDR_W)) u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr_q (addr_q),
        .mem_io (mem_io),
        .rd     (rd),
        .wr     (wr),
        .in_en  (in_en),
        .out_en (out_en)
    );

    io_pd_out_bank #(.NPORTS(NPORTS), .DATA_W(DATA_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .out_en   (out_en),
        .bus_in   (bus_in),
        .out_regs (out_regs)
    );

    io_pd_in_mux #(.NPORTS(NPORTS), .DATA_W(DATA_W)) u_in (
        .in_en        (in_en),
        .in_port_data (in_port_data),
        .bus_out      (bus_out),
        .bus_oe       (bus_oe)
    );

    // R9: bus driven only in a qualified read cycle
    a_r9_drive_read: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> (!mem_io && rd && !wr));

    // R9: block releases the bus outside read cycles
    a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> (bus_out == '0));

endmodule

// File: tb/io_pd_top_bench.sv
`timescale 1ns/1ps
module io_pd_top_bench;

    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;
    localparam int NPORTS = 1 << ADDR_W;

    // Stimulus table: {mem_io, rd, wr, expected kind}; kind 0 none, 1 out, 2 in.
    localparam logic [4:0] VEC [8] = '{
        {1'b0, 1'b0, 1'b0, 2'd0},
        {1'b0, 1'b0, 1'b1, 2'd1},
        {1'b0, 1'b1, 1'b0, 2'd2},
        {1'b0, 1'b1, 1'b1, 2'd0},
        {1'b1, 1'b0, 1'b0, 2'd0},
        {1'b1, 1'b0, 1'b1, 2'd0},
        {1'b1, 1'b1, 1'b0, 2'd0},
        {1'b1, 1'b1, 1'b1, 2'd0}
    };

    logic                     clk = 0;
    logic                     rst_n = 0;
    logic                     ale = 0, mem_io = 1, rd = 0, wr = 0;
    logic [DATA_W-1:0]        bus_in = '0;
    logic [NPORTS*DATA_W-1:0] in_port_data;
    logic [NPORTS-1:0]        in_en, out_en;
    logic [NPORTS*DATA_W-1:0] out_regs;
    logic [DATA_W-1:0]        bus_out;
    logic                     bus_oe;

    logic [NPORTS*DATA_W-1:0] model_regs = '0;
    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    io_pd_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_io_pd_top (
        .clk(clk), .rst_n(rst_n), .ale(ale), .mem_io(mem_io), .rd(rd), .wr(wr),
        .bus_in(bus_in), .in_port_data(in_port_data), .in_en(in_en),
        .out_en(out_en), .out_regs(out_regs), .bus_out(bus_out), .bus_oe(bus_oe)
    );

    task automatic chk(input string req, input string what,
                       input logic [NPORTS*DATA_W-1:0] act,
                       input logic [NPORTS*DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Address phase, then data phase with the given strobes.
    task automatic start_cycle(input int a, input logic [DATA_W-1:0] d,
                               input logic m, input logic r, input logic w);
        @(negedge clk);
        ale = 1; bus_in = DATA_W'(a); mem_io = 1; rd = 0; wr = 0;
        @(negedge clk);
        ale = 0; bus_in = d; mem_io = m; rd = r; wr = w;
        #1;
    endtask

    // Close the cycle after one clock edge and update the model.
    task automatic end_cycle(input int a, input logic [DATA_W-1:0] d, input bit wrote);
        @(negedge clk);
        mem_io = 1; rd = 0; wr = 0;
        if (wrote) model_regs[a*DATA_W +: DATA_W] = d;
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int k = 0; k < NPORTS; k++)
            in_port_data[k*DATA_W +: DATA_W] = DATA_W'(k * 37 + 5);

        repeat (3) @(negedge clk);
        #1;
        // R8: reset state
        chk("R8", "reset out_regs", out_regs, '0);
        chk("R8", "reset enables", {in_en, out_en}, '0);
        rst_n = 1;

        // Table walk: every address against every strobe combination (R2..R6, R9, R7, R8).
        for (int v = 0; v < 8; v++) begin
            for (int a = 0; a < NPORTS; a++) begin
                logic m, r, w;
                logic [1:0] kind;
                logic [DATA_W-1:0] d;
                logic [NPORTS-1:0] e_out, e_in;
                string tag;
                {m, r, w, kind} = VEC[v];
                d = DATA_W'((a * 16 + v) ^ 8'h5A);
                e_out = (kind == 2'd1) ? (NPORTS'(1) << a) : '0;
                e_in  = (kind == 2'd2) ? (NPORTS'(1) << a) : '0;
                tag = m ? "R4" : (r && w) ? "R5" : w ? "R2" : r ? "R3" : "R6";
                start_cycle(a, d, m, r, w);
                chk(tag, "out_en", NPORTS*DATA_W'(out_en), NPORTS*DATA_W'(e_out));
                chk(tag, "in_en", NPORTS*DATA_W'(in_en), NPORTS*DATA_W'(e_in));
                chk("R9", "bus_oe", NPORTS*DATA_W'(bus_oe), NPORTS*DATA_W'(kind == 2'd2));
                chk("R9", "bus_out", NPORTS*DATA_W'(bus_out),
                    (kind == 2'd2) ? NPORTS*DATA_W'(in_port_data[a*DATA_W +: DATA_W]) : '0);
                end_cycle(a, d, kind == 2'd1);
                chk((kind == 2'd1) ? "R7" : "R8", "out_regs", out_regs, model_regs);
            end
        end

        // R1: address held while later bus values pass with ale low
        @(negedge clk); ale = 1; bus_in = 8'h05;
        @(negedge clk); ale = 0; bus_in = 8'hF3;
        @(negedge clk); bus_in = 8'h0C;
        @(negedge clk); mem_io = 0; rd = 1; #1;
        chk("R1", "held address read enable", NPORTS*DATA_W'(in_en), NPORTS*DATA_W'(16'h0020));
        end_cycle(0, '0, 0);

        // R10: write then read the same port number 3
        start_cycle(3, 8'hC7, 0, 0, 1);
        end_cycle(3, 8'hC7, 1);
        start_cycle(3, 8'h11, 0, 1, 0);
        chk("R10", "read port 3 data", NPORTS*DATA_W'(bus_out),
            NPORTS*DATA_W'(in_port_data[3*DATA_W +: DATA_W]));
        end_cycle(3, 8'h11, 0);
        chk("R10", "out reg 3 after read", NPORTS*DATA_W'(out_regs[3*DATA_W +: DATA_W]),
            NPORTS*DATA_W'(8'hC7));

        // R8: reset clears registers and held address
        start_cycle(9, 8'h99, 1, 0, 0);
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1; #1;
        chk("R8", "out_regs after reset", out_regs, '0);
        @(negedge clk); mem_io = 0; rd = 1; #1;
        chk("R8", "address after reset", NPORTS*DATA_W'(in_en), NPORTS*DATA_W'(1));
        @(negedge clk); mem_io = 1; rd = 0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule